// File: doc/BRIEF.md
# Saturating Add, Subtract and Clamp Unit

This unit serves fixed-point signal-processing datapaths that must never wrap on overflow. Each cycle with the input strobe high, it takes two 32-bit signed operands and an operation code. It then does one of four things: a signed add that saturates, a signed subtract that saturates, a clamp of the first operand into a signed range of programmable width, or a clamp into an unsigned range of programmable width.

When a true result falls outside the representable range, the unit returns the nearest extreme instead of the wrapped value. It also raises a per-operation indication that clamping took place. A sticky flag gathers every saturation event until a clear pulse arrives. The result and both flags are registered, so software or downstream logic reads them exactly one cycle after the request.

Top module: `sat_unit`

## Requirements
- R1: With op = 2'b00 the result is a + b (signed); a true sum above 2^31−1 gives 0x7FFFFFFF and a true sum below −2^31 gives 0x80000000, and otherwise the result is the exact sum.
- R2: With op = 2'b01 the result is a − b (signed), using the same clamping to 0x7FFFFFFF and 0x80000000 as R1.
- R3: With op = 2'b10 the operand a is clamped to the signed range of n = sat_width+1 bits (n from 1 to 32), that is, −2^(n−1) to 2^(n−1)−1. Operand b is ignored.
- R4: With op = 2'b11 the operand a is clamped to the unsigned range of n = sat_width bits (n from 0 to 31), that is, 0 to 2^n−1. Any negative input gives 0, and operand b is ignored.
- R5: The result and out_valid appear on the clock edge after a cycle with in_valid high. In a cycle with in_valid low, out_valid and sat_hit go low one edge later and result keeps its previous value.
- R6: sat_hit is high together with a result exactly when that result differs from the exact mathematical value of the operation.
- R7: sticky_sat is set by any saturating operation and stays set until sticky_clr is high on a clock edge. If a saturating operation and sticky_clr arrive in the same cycle, the flag ends up set.
- R8: Synchronous active-high reset clears result, out_valid, sat_hit and sticky_sat to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 2 | Operation: 00 add, 01 subtract, 10 signed clamp, 11 unsigned clamp |
| opnd_a | input | 32 | First operand (signed) |
| opnd_b | input | 32 | Second operand (signed), used by add and subtract |
| sat_width | input | 5 | Clamp width code (see R3, R4) |
| sticky_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| sat_hit | output | 1 | The current result was clamped |
| sticky_sat | output | 1 | Accumulated saturation flag |

## Verification
Each result, sat_hit and out_valid is due on the first rising edge after the cycle in which the request is driven. The sticky flag responds to a clear or to a saturation on that same edge. The bench drives inputs on the falling edge, waits for one rising edge, and samples 1 ns later, so every check reads the value written by exactly that edge. Idle cycles are checked the same way to confirm that the result holds and that the indications drop.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int DATA_W  = 32;
    localparam int WIDTH_W = $clog2(DATA_W);
    localparam int WIDE_W  = DATA_W + 1;

    typedef enum logic [1:0] {
        OP_SADD    = 2'b00,
        OP_SSUB    = 2'b01,
        OP_CLAMP_S = 2'b10,
        OP_CLAMP_U = 2'b11
    } sat_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              hit;
    } sat_res_t;

    localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic signed [WIDE_W-1:0] widen(input logic [DATA_W-1:0] v);
        return $signed({v[DATA_W-1], v});
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output sat_res_t          res
);
    logic signed [WIDE_W-1:0] wide_a;
    logic signed [WIDE_W-1:0] wide_b;
    logic signed [WIDE_W-1:0] wide_sum;
    logic                     too_big;
    logic                     too_small;

    always_comb begin
        wide_a   = widen(a);
        wide_b   = widen(b);
        wide_sum = do_sub ? (wide_a - wide_b) : (wide_a + wide_b);
        // the top two bits disagree only when the sum left the DATA_W range
        too_big   = !wide_sum[WIDE_W-1] &&  wide_sum[WIDE_W-2];
        too_small =  wide_sum[WIDE_W-1] && !wide_sum[WIDE_W-2];
        res.hit   = too_big || too_small;
        if (too_big)
            res.value = POS_LIMIT;
        else if (too_small)
            res.value = NEG_LIMIT;
        else
            res.value = wide_sum[DATA_W-1:0];
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
    import sat_pkg::*;
(
    input  logic [DATA_W-1:0]  val,
    input  logic [WIDTH_W-1:0] width_code,
    input  logic               as_unsigned,
    output sat_res_t           res
);
    localparam int NB_W = WIDTH_W + 1;

    logic [NB_W-1:0]          nbits;
    logic signed [WIDE_W-1:0] hi_lim;
    logic signed [WIDE_W-1:0] lo_lim;
    logic signed [WIDE_W-1:0] wide_v;
    logic signed [WIDE_W-1:0] one_w;

    always_comb begin
        one_w  = {{(WIDE_W-1){1'b0}}, 1'b1};
        wide_v = widen(val);
        if (as_unsigned) begin
            nbits  = {1'b0, width_code};
            hi_lim = (one_w <<< nbits) - one_w;
            lo_lim = '0;
        end else begin
            nbits  = {1'b0, width_code} + 1'b1;
            hi_lim = (one_w <<< (nbits - 1'b1)) - one_w;
            lo_lim = -(one_w <<< (nbits - 1'b1));
        end
        if (wide_v > hi_lim) begin
            res.value = hi_lim[DATA_W-1:0];
            res.hit   = 1'b1;
        end else if (wide_v < lo_lim) begin
            res.value = lo_lim[DATA_W-1:0];
            res.hit   = 1'b1;
        end else begin
            res.value = val;
            res.hit   = 1'b0;
        end
    end
endmodule

// File: rtl/sat_unit.sv
module sat_unit
    import sat_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         op,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [WIDTH_W-1:0] sat_width,
    input  logic               sticky_clr,
    output logic               out_valid,
    output logic [DATA_W-1:0]  result,
    output logic               sat_hit,
    output logic               sticky_sat
);
    sat_op_e  op_e;
    sat_res_t arith_res;
    sat_res_t clamp_res;
    sat_res_t pick;

    assign op_e = sat_op_e'(op);

    sat_addsub u_addsub (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (op_e == OP_SSUB),
        .res    (arith_res)
    );

    sat_clamp u_clamp (
        .val         (opnd_a),
        .width_code  (sat_width),
        .as_unsigned (op_e == OP_CLAMP_U),
        .res         (clamp_res)
    );

    always_comb begin
        unique case (op_e)
            OP_SADD, OP_SSUB: pick = arith_res;
            default:          pick = clamp_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            sat_hit    <= 1'b0;
            sticky_sat <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sat_hit   <= in_valid && pick.hit;
            if (in_valid)
                result <= pick.value;
            if (in_valid && pick.hit)
                sticky_sat <= 1'b1;
            else if (sticky_clr)
                sticky_sat <= 1'b0;
        end
    end

    // R1
    add_pos_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_SADD && !opnd_a[DATA_W-1] && !opnd_b[DATA_W-1])
        |=> !result[DATA_W-1]);

    // R1
    add_neg_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_SADD && opnd_a[DATA_W-1] && opnd_b[DATA_W-1])
        |=> result[DATA_W-1]);

    // R4
    uclamp_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_e == OP_CLAMP_U) |=> !result[DATA_W-1]);

    // R5
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> (!out_valid && !sat_hit && $stable(result)));

    // R7
    sticky_follows_hit_chk: assert property (@(posedge clk) disable iff (rst)
        sat_hit |-> sticky_sat);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_sat && !sticky_clr) |=> sticky_sat);

endmodule

// File: tb/sat_unit_tb.sv
module sat_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [4:0]  sat_width;
    logic        sticky_clr;
    logic        out_valid;
    logic [31:0] result;
    logic        sat_hit;
    logic        sticky_sat;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  exp_sticky = 1'b0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sat_unit u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op         (op),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .sat_width  (sat_width),
        .sticky_clr (sticky_clr),
        .out_valid  (out_valid),
        .result     (result),
        .sat_hit    (sat_hit),
        .sticky_sat (sticky_sat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [1:0] o, input logic [31:0] a,
                                  input logic [31:0] b, input logic [4:0] w,
                                  output logic [31:0] r, output bit s);
        longint x, hi, lo;
        int n;
        hi = 64'sd2147483647;
        lo = -64'sd2147483648;
        case (o)
            2'b00: x = longint'($signed(a)) + longint'($signed(b));
            2'b01: x = longint'($signed(a)) - longint'($signed(b));
            2'b10: begin
                x  = longint'($signed(a));
                n  = int'(w) + 1;
                hi = (64'sd1 <<< (n - 1)) - 1;
                lo = -(64'sd1 <<< (n - 1));
            end
            default: begin
                x  = longint'($signed(a));
                n  = int'(w);
                hi = (64'sd1 <<< n) - 1;
                lo = 0;
            end
        endcase
        if (x > hi)      r = hi[31:0];
        else if (x < lo) r = lo[31:0];
        else             r = x[31:0];
        s = (longint'($signed(r)) != x);
    endfunction

    task automatic run_op(input string tag, input logic [1:0] o, input logic [31:0] a,
                          input logic [31:0] b, input logic [4:0] w);
        logic [31:0] er;
        bit es;
        model(o, a, b, w, er, es);
        @(negedge clk);
        in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; sat_width = w;
        @(posedge clk); #1;
        exp_sticky = exp_sticky | es;
        chk({tag, " result"}, result, er);
        chk({tag, " R6 sat_hit"}, {31'd0, sat_hit}, {31'd0, es});
        chk({tag, " R5 out_valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " R7 sticky"}, {31'd0, sticky_sat}, {31'd0, exp_sticky});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; op = 2'b00; opnd_a = '0; opnd_b = '0;
        sat_width = '0; sticky_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8 result", result, 32'd0);
        chk("R8 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R8 sat_hit", {31'd0, sat_hit}, 32'd0);
        chk("R8 sticky", {31'd0, sticky_sat}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_add;
        run_op("R1 plain", 2'b00, 32'd100, 32'hFFFF_FFF6, 5'd0);
        run_op("R1 pos ovf", 2'b00, 32'h7FFF_FFFF, 32'd1, 5'd0);
        run_op("R1 neg ovf", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 5'd0);
        run_op("R1 edge max", 2'b00, 32'h7FFF_FFFE, 32'd1, 5'd0);
        run_op("R1 big neg", 2'b00, 32'h8000_0000, 32'h8000_0000, 5'd0);
    endtask

    task automatic t_sub;
        run_op("R2 plain", 2'b01, 32'd5, 32'd9, 5'd0);
        run_op("R2 pos ovf", 2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
        run_op("R2 neg ovf", 2'b01, 32'h8000_0000, 32'd1, 5'd0);
        run_op("R2 min minus zero", 2'b01, 32'h8000_0000, 32'd0, 5'd0);
    endtask

    task automatic t_sclamp;
        run_op("R3 8bit hi", 2'b10, 32'd300, 32'h1234_5678, 5'd7);
        run_op("R3 8bit lo", 2'b10, 32'hFFFF_FF00, 32'd0, 5'd7);
        run_op("R3 8bit in", 2'b10, 32'hFFFF_FF80, 32'd0, 5'd7);
        run_op("R3 1bit", 2'b10, 32'd1, 32'd0, 5'd0);
        run_op("R3 32bit", 2'b10, 32'h8000_0000, 32'd7, 5'd31);
    endtask

    task automatic t_uclamp;
        run_op("R4 neg", 2'b11, 32'hFFFF_FFFF, 32'd0, 5'd8);
        run_op("R4 8bit hi", 2'b11, 32'd256, 32'hFFFF_FFFF, 5'd8);
        run_op("R4 8bit in", 2'b11, 32'd255, 32'd0, 5'd8);
        run_op("R4 zero width", 2'b11, 32'd1, 32'd0, 5'd0);
        run_op("R4 31bit", 2'b11, 32'h7FFF_FFFF, 32'd0, 5'd31);
    endtask

    task automatic t_idle;
        logic [31:0] held;
        run_op("R5 setup", 2'b00, 32'h7FFF_FFFF, 32'd5, 5'd0);
        held = result;
        @(negedge clk);
        in_valid = 1'b0; op = 2'b01; opnd_a = 32'd1; opnd_b = 32'd2;
        @(posedge clk); #1;
        chk("R5 idle out_valid", {31'd0, out_valid}, 32'd0);
        chk("R5 idle sat_hit", {31'd0, sat_hit}, 32'd0);
        chk("R5 idle result held", result, held);
    endtask

    task automatic t_sticky;
        run_op("R7 set", 2'b00, 32'h7FFF_FFFF, 32'd1, 5'd0);
        run_op("R7 keep", 2'b00, 32'd1, 32'd1, 5'd0);
        @(negedge clk);
        sticky_clr = 1'b1;
        @(posedge clk); #1;
        exp_sticky = 1'b0;
        chk("R7 cleared", {31'd0, sticky_sat}, 32'd0);
        @(negedge clk);
        sticky_clr = 1'b0;
        run_op("R7 stays clear", 2'b01, 32'd3, 32'd1, 5'd0);
        @(negedge clk);
        sticky_clr = 1'b1; in_valid = 1'b1; op = 2'b11;
        opnd_a = 32'hFFFF_0000; opnd_b = 32'd0; sat_width = 5'd4;
        @(posedge clk); #1;
        exp_sticky = 1'b1;
        chk("R7 set beats clear", {31'd0, sticky_sat}, 32'd1);
        chk("R4 clear-cycle result", result, 32'd0);
        @(negedge clk);
        sticky_clr = 1'b0; in_valid = 1'b0;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_sclamp();
        t_uclamp();
        t_idle();
        t_sticky();
        repeat (2) @(posedge clk);
        summary();
    end

endmodule